// File: doc/BRIEF.md
# Floating-Point Status Word with Compare Queue

This block keeps the 32-bit status word that sits beside a floating-point datapath. Software can load the whole word at once. Two control fields are decoded from the word and drive the datapath: a two-bit rounding mode and a flush-to-zero enable. After each arithmetic operation, the datapath reports a five-bit vector of raw exception flags. The block ORs those flags into a sticky field at the top of the word. If any flag that was just raised is also enabled, the block issues a one-cycle assist trap.

Compare operations report a relation code and a four-bit condition selector. From these the block forms a single outcome bit. A non-zero target index writes that bit into one selected condition position. A zero target index pushes the bit into the main compare position, and the previous main bit shifts into a ten-entry history queue below it. The status word, the decoded controls and the trap are all outputs; the arithmetic itself is outside this block.

Top module: `fp_status_word`

## Requirements
- R1: After reset the status word is zero, trapPulse is low, roundMode is 0 and flushZero is low.
- R2: When swWrEn is high, the whole word is replaced by swWrData on the next clock. This takes priority over any flag or compare in the same cycle: those are dropped and no trap is raised.
- R3: roundMode follows word bits 10:9 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and flushZero follows word bit 5.
- R4: When flagValid is high, flagRaw bit i (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into word bit 27+i. These bits stay set until software writes the word.
- R5: A flag report with an all-zero vector leaves the whole word unchanged.
- R6: On the clock after a flag report, trapPulse is high exactly when flagRaw ANDed with the enable bits 4:0 of the word held before that clock is non-zero.
- R7: The compare outcome is a bit of cmpCond selected by cmpRel: code 0 (greater) selects bit 4, code 1 (less) bit 3, code 2 (equal) bit 2, code 3 (unordered) bit 1.
- R8: A compare with cmpTarget y in 1..10 writes the outcome into word bit 22-y and leaves all other bits unchanged.
- R9: A compare with cmpTarget 0 moves word bits 21:12 into bits 20:11, moves the old bit 26 into bit 21, and writes the outcome into bit 26.
- R10: A compare with cmpTarget in 11..15 leaves the word unchanged.
- R11: A flag report and a compare in the same cycle both take effect on the same clock.
- R12: trapPulse lasts one cycle. It is low on any clock that had no accepted flag report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Word to load |
| flagValid | input | 1 | Flag report strobe from the datapath |
| flagRaw | input | 5 | Raw exception flags of one operation |
| cmpValid | input | 1 | Compare result strobe |
| cmpRel | input | 2 | Relation code of the compare |
| cmpCond | input | 4 | Condition selector, bits 4:1 |
| cmpTarget | input | 4 | Target index; 0 selects the queue |
| statusWord | output | 32 | Current status word |
| roundMode | output | 2 | Decoded rounding mode |
| flushZero | output | 1 | Flush-to-zero enable |
| trapPulse | output | 1 | One-cycle assist trap |

## Verification
A flag report and a compare can arrive on the same clock. A software write can also collide with both. Flag and compare updates touch disjoint bit fields, so the bench sweeps all 32 flag vectors against every relation and several target indices in a single cycle, and compares the result with a model that applies the flag merge and then the compare. The bench also issues a software write together with a trapping flag report and a compare. It then requires the loaded word to appear unaltered and the trap to stay low.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int WORD_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int Q_DEPTH  = 10;
  localparam int TGT_W    = 4;
  localparam int POS_W    = $clog2(WORD_W);
  localparam int FLAG_LSB = WORD_W - FLAG_W;
  localparam int MAIN_BIT = 26;
  localparam int Q_TOP    = 21;
  localparam int Q_LOW    = Q_TOP - Q_DEPTH + 1;
  localparam int RM_LSB   = 9;
  localparam int FTZ_BIT  = 5;
  localparam int ENA_LSB  = 0;

  typedef enum logic [1:0] {REL_GT, REL_LT, REL_EQ, REL_UN} relT;
  typedef enum logic [1:0] {RND_NEAREST, RND_ZERO, RND_UP, RND_DOWN} rndT;

  typedef struct packed {
    logic             load;
    logic             accum;
    logic             cmpQueue;
    logic             cmpTarget;
    logic             outcome;
    logic [POS_W-1:0] tgtBit;
  } ctrlT;
endpackage

// File: rtl/fpsw_ctrl.sv
module fpsw_ctrl
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic              flagValid,
  input  logic [FLAG_W-1:0] flagRaw,
  input  logic [FLAG_W-1:0] enables,
  input  logic              cmpValid,
  input  logic [1:0]        cmpRel,
  input  logic [4:1]        cmpCond,
  input  logic [TGT_W-1:0]  cmpTarget,
  output ctrlT              ctrl,
  output logic              trapPulse
);
  logic outcomeBit;
  logic tgtInRange;
  logic trapReq;
  logic trapQ;

  // relation picks one condition bit
  always_comb begin
    unique case (relT'(cmpRel))
      REL_GT:  outcomeBit = cmpCond[4];
      REL_LT:  outcomeBit = cmpCond[3];
      REL_EQ:  outcomeBit = cmpCond[2];
      default: outcomeBit = cmpCond[1];
    endcase
  end

  assign tgtInRange = (cmpTarget != '0) && (int'(cmpTarget) <= Q_DEPTH);

  always_comb begin
    ctrl.load      = swWrEn;
    ctrl.accum     = flagValid && !swWrEn;
    ctrl.cmpQueue  = cmpValid && !swWrEn && (cmpTarget == '0);
    ctrl.cmpTarget = cmpValid && !swWrEn && tgtInRange;
    ctrl.outcome   = outcomeBit;
    ctrl.tgtBit    = POS_W'(Q_TOP + 1) - POS_W'(cmpTarget);
  end

  assign trapReq = ctrl.accum && ((flagRaw & enables) != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapQ <= 1'b0;
    else       trapQ <= trapReq;
  end

  assign trapPulse = trapQ;
endmodule

// File: rtl/fpsw_datapath.sv
module fpsw_datapath
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagRaw,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] wordQ;
  logic [WORD_W-1:0] afterFlags;
  logic [WORD_W-1:0] afterCmp;

  always_comb begin
    afterFlags = wordQ;
    if (ctrl.accum)
      afterFlags[FLAG_LSB +: FLAG_W] = wordQ[FLAG_LSB +: FLAG_W] | flagRaw;
  end

  always_comb begin
    afterCmp = afterFlags;
    if (ctrl.cmpQueue) begin
      for (int i = Q_LOW - 1; i < Q_TOP; i++)
        afterCmp[i] = afterFlags[i+1];
      afterCmp[Q_TOP]    = afterFlags[MAIN_BIT];
      afterCmp[MAIN_BIT] = ctrl.outcome;
    end else if (ctrl.cmpTarget) begin
      afterCmp[ctrl.tgtBit] = ctrl.outcome;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wordQ <= '0;
    else if (ctrl.load) wordQ <= wrData;
    else                wordQ <= afterCmp;
  end

  assign word = wordQ;
endmodule

// File: rtl/fp_status_word.sv
module fp_status_word
  import fpsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swWrEn,
  input  logic [31:0] swWrData,
  input  logic        flagValid,
  input  logic [4:0]  flagRaw,
  input  logic        cmpValid,
  input  logic [1:0]  cmpRel,
  input  logic [4:1]  cmpCond,
  input  logic [3:0]  cmpTarget,
  output logic [31:0] statusWord,
  output logic [1:0]  roundMode,
  output logic        flushZero,
  output logic        trapPulse
);
  ctrlT              ctrl;
  logic [WORD_W-1:0] word;

  fpsw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .swWrEn    (swWrEn),
    .flagValid (flagValid),
    .flagRaw   (flagRaw),
    .enables   (word[ENA_LSB +: FLAG_W]),
    .cmpValid  (cmpValid),
    .cmpRel    (cmpRel),
    .cmpCond   (cmpCond),
    .cmpTarget (cmpTarget),
    .ctrl      (ctrl),
    .trapPulse (trapPulse)
  );

  fpsw_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrData  (swWrData),
    .flagRaw (flagRaw),
    .word    (word)
  );

  assign statusWord = word;
  assign roundMode  = word[RM_LSB +: 2];
  assign flushZero  = word[FTZ_BIT];
endmodule

// File: rtl/fpsw_checker.sv
module fpsw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        swWrEn,
  input logic [31:0] swWrData,
  input logic        flagValid,
  input logic [4:0]  flagRaw,
  input logic        cmpValid,
  input logic [3:0]  cmpTarget,
  input logic [31:0] statusWord,
  input logic        trapPulse
);
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> statusWord == $past(swWrData)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> (statusWord[31:27] & $past(statusWord[31:27])) == $past(statusWord[31:27])); // R4

  AST_FLAG_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (flagValid && !swWrEn) |=> statusWord[31:27] == ($past(statusWord[31:27]) | $past(flagRaw))); // R4

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(flagValid && !swWrEn)); // R12

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !swWrEn && cmpTarget == 4'd0) |=>
      (statusWord[20:11] == $past(statusWord[21:12])) && (statusWord[21] == $past(statusWord[26]))); // R9

  AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !swWrEn && !flagValid && cmpTarget > 4'd10) |=> $stable(statusWord)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && !flagValid && !cmpValid) |=> $stable(statusWord)); // R5
endmodule

bind fp_status_word fpsw_checker u_chk (.*);

// File: tb/fp_status_word_bench.sv
`timescale 1ns/100ps
module fp_status_word_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        flagValid = 1'b0;
  logic [4:0]  flagRaw = '0;
  logic        cmpValid = 1'b0;
  logic [1:0]  cmpRel = '0;
  logic [4:1]  cmpCond = '0;
  logic [3:0]  cmpTarget = '0;
  logic [31:0] statusWord;
  logic [1:0]  roundMode;
  logic        flushZero;
  logic        trapPulse;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_status_word u_fp_status_word (.*);

  function automatic logic [31:0] scramble(input int n);
    logic [31:0] x;
    x = 32'h9E3779B9 * (n + 7);
    x = x ^ (x >> 15) ^ (x << 11);
    return x;
  endfunction

  // expected next word from the requirements
  function automatic logic [31:0] model(input logic [31:0] old, input bit fv,
      input logic [4:0] raw, input bit cv, input int rel, input logic [4:1] cond,
      input int y);
    logic [31:0] w;
    logic o;
    w = old;
    if (fv) w = w | ({27'd0, raw} << 27);
    case (rel)
      0: o = cond[4];
      1: o = cond[3];
      2: o = cond[2];
      default: o = cond[1];
    endcase
    if (cv) begin
      if (y == 0) begin
        w = (w & ~(32'h7FF << 11)) | (((old >> 12) & 32'h3FF) << 11)
            | ({31'd0, old[26]} << 21);
        w[26] = o;
      end else if (y <= 10) begin
        w[22 - y] = o;
      end
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    swWrEn = 0; flagValid = 0; cmpValid = 0;
  endtask

  task automatic load(input logic [31:0] w);
    swWrEn = 1; swWrData = w;
    @(negedge clk);
    idle();
  endtask

  task automatic op(input bit fv, input logic [4:0] raw, input bit cv,
      input int rel, input logic [4:1] cond, input int y);
    flagValid = fv; flagRaw = raw; cmpValid = cv;
    cmpRel = 2'(rel); cmpCond = cond; cmpTarget = 4'(y);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pre;
    logic [31:0] exp;
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    check("R1 word", statusWord, 32'd0);
    check("R1 trap", {31'd0, trapPulse}, 32'd0);
    check("R1 round", {30'd0, roundMode}, 32'd0);
    check("R1 ftz", {31'd0, flushZero}, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R3 control decode
    for (int rm = 0; rm < 4; rm++) begin
      for (int fz = 0; fz < 2; fz++) begin
        pre = scramble(rm * 2 + fz);
        pre[10:9] = 2'(rm); pre[5] = fz[0];
        load(pre);
        check("R2 load", statusWord, pre);
        check("R3 round", {30'd0, roundMode}, 32'(rm));
        check("R3 ftz", {31'd0, flushZero}, 32'(fz));
      end
    end

    // R7 R8 R9 R10 compare sweep
    for (int rel = 0; rel < 4; rel++)
      for (int c = 0; c < 16; c++)
        for (int y = 0; y < 16; y++) begin
          pre = scramble(n++);
          load(pre);
          op(0, 5'd0, 1, rel, 4'(c), y);
          exp = model(pre, 0, 5'd0, 1, rel, 4'(c), y);
          check("R7 R8 R9 R10 compare", statusWord, exp);
          check("R12 no trap on compare", {31'd0, trapPulse}, 32'd0);
        end

    // R4 R5 R6 flag sweep
    for (int raw = 0; raw < 32; raw++)
      for (int en = 0; en < 32; en++) begin
        pre = scramble(n++);
        pre[4:0] = 5'(en);
        load(pre);
        op(1, 5'(raw), 0, 0, 4'd0, 0);
        exp = model(pre, 1, 5'(raw), 0, 0, 4'd0, 0);
        check(raw == 0 ? "R5 zero flags" : "R4 flag merge", statusWord, exp);
        check("R6 trap", {31'd0, trapPulse}, {31'd0, ((raw & en) != 0)});
        @(negedge clk);
        check("R12 trap one cycle", {31'd0, trapPulse}, 32'd0);
      end

    // R11 flag and compare together
    for (int raw = 0; raw < 32; raw++)
      for (int rel = 0; rel < 4; rel++)
        for (int yi = 0; yi < 4; yi++) begin
          int y;
          y = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 10 : 12;
          pre = scramble(n++);
          load(pre);
          op(1, 5'(raw), 1, rel, 4'(raw >> 1), y);
          exp = model(pre, 1, 5'(raw), 1, rel, 4'(raw >> 1), y);
          check("R11 flag with compare", statusWord, exp);
        end

    // R2 write wins over flag and compare
    for (int k = 0; k < 16; k++) begin
      pre = scramble(n++) | 32'h1F;
      load(scramble(n++) | 32'h1F);
      swWrEn = 1; swWrData = pre;
      flagValid = 1; flagRaw = 5'h1F; cmpValid = 1;
      cmpRel = 2'(k); cmpCond = 4'hF; cmpTarget = 4'(k);
      @(negedge clk);
      idle();
      check("R2 write priority", statusWord, pre);
      check("R2 no trap on write", {31'd0, trapPulse}, 32'd0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule